// File: doc/BRIEF.md
# Program Sequencer with Return Stack

This block is the instruction-address engine of a small microcontroller core. It keeps a 13-bit program counter that names the instruction executing in the current cycle, and a circular stack of return addresses. On every enabled cycle it acts on one control pulse from the instruction decoder. The possible actions are:

- advance by one;
- jump or call to a target formed from two latch bits and an 11-bit immediate;
- return through the stack;
- load the counter from a low-byte write;
- skip the following instruction when a test result says so.

Every action that breaks the sequential flow costs two cycles. The second cycle is a dead slot that the block flags with `flush`. During that slot the counter holds and all decoder pulses are discarded. The decoder and the ALU use `flush` to turn the instruction in that slot into a no-op. A taken skip therefore takes two cycles and an untaken skip takes one. Two single-cycle strobes tell the rest of the core that an interrupt-return has executed (set the global interrupt enable) or that a literal-return has executed (load the working register with its literal).

Top module: `pc_seq`

## Requirements
- R1: Reset drives `pc` to 0 and `flush` to 0, and clears every stack entry and the stack pointer, so a return executed straight after reset goes to address 0.
- R2: On an enabled cycle with no flush and no decoder pulse (or an untaken skip), `pc` advances by one modulo 2^13 (0x1FFF wraps to 0) and `flush` is 0 afterwards.
- R3: While `cyc_en` is low, `pc`, `flush` and the stack do not change and both strobes stay low.
- R4: A jump sets `pc` to {`pc_latch`[4:3], `jmp_imm`[10:0]} and raises `flush` for the next cycle.
- R5: A call pushes `pc`+1 onto the stack, sets `pc` to the same target a jump would, and raises `flush`.
- R6: A return, literal-return or interrupt-return pops the most recent stack entry into `pc` and raises `flush`; nested calls come back in reverse order.
- R7: `gie_set` is high only in the enabled, non-flush cycle of an interrupt-return that wins priority, and `lit_load` is high only in the same kind of cycle of a literal-return that wins priority.
- R8: A skip-class instruction with `skip_cond` high advances `pc` by two and raises `flush`; with `skip_cond` low it behaves as R2.
- R9: In an enabled cycle with `flush` high, `pc` holds, every decoder pulse is ignored (no push, no pop, no strobe), and `flush` falls.
- R10: A low-byte write sets `pc` to {`pc_latch`[4:0], `pcl_wdata`[7:0]} and raises `flush`.
- R11: The stack is 8 deep and circular: a ninth push overwrites the oldest entry, so after nine calls, nine returns give the ninth..second return addresses followed by the ninth again.
- R12: When several pulses arrive together, only one acts, in the priority low-byte write, jump, call, return, literal-return, interrupt-return, skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Instruction-cycle strobe; the block acts only when high |
| op_jump | input | 1 | Absolute jump pulse |
| op_call | input | 1 | Subroutine call pulse |
| op_ret | input | 1 | Plain return pulse |
| op_retlit | input | 1 | Return-with-literal pulse |
| op_retint | input | 1 | Return-from-interrupt pulse |
| op_skip | input | 1 | Skip-class instruction executing |
| skip_cond | input | 1 | Test result: high means skip the next instruction |
| pcl_wr | input | 1 | Write to the counter low byte |
| pcl_wdata | input | 8 | Data for the low-byte write |
| jmp_imm | input | 11 | Immediate target field of jump and call |
| pc_latch | input | 5 | Upper-address latch |
| pc | output | 13 | Address of the instruction in the current cycle |
| flush | output | 1 | Current cycle is a dead slot of a two-cycle action |
| gie_set | output | 1 | Interrupt-return executed this cycle |
| lit_load | output | 1 | Literal-return executed this cycle |

## Verification
A corrupted stack pointer or entry stays hidden until the next return. It then shows up as a wrong `pc` one clock after that return, which can be long after the fault. The bench therefore nests calls past the stack depth and pops all the way out. A stuck or missing `flush` shows up one cycle later, as a `pc` that moves or executes a pulse in what should be a dead slot. A wrong priority or target slice shows up as a wrong `pc` on the very next edge.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
   typedef enum logic [2:0] {
      ACT_IDLE,
      ACT_DEAD,
      ACT_STEP,
      ACT_SKIP,
      ACT_JUMP,
      ACT_CALL,
      ACT_POP,
      ACT_PCL
   } act_e;
endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
   import pc_seq_pkg::*;
(
   input  logic cyc_en,
   input  logic flush,
   input  logic op_jump,
   input  logic op_call,
   input  logic op_ret,
   input  logic op_retlit,
   input  logic op_retint,
   input  logic op_skip,
   input  logic skip_cond,
   input  logic pcl_wr,
   output act_e act,
   output logic gie_set,
   output logic lit_load
);
   always_comb begin
      act      = ACT_IDLE;
      gie_set  = 1'b0;
      lit_load = 1'b0;
      if (cyc_en) begin
         if (flush) begin
            act = ACT_DEAD;
         end else if (pcl_wr) begin
            act = ACT_PCL;
         end else if (op_jump) begin
            act = ACT_JUMP;
         end else if (op_call) begin
            act = ACT_CALL;
         end else if (op_ret) begin
            act = ACT_POP;
         end else if (op_retlit) begin
            act      = ACT_POP;
            lit_load = 1'b1;
         end else if (op_retint) begin
            act     = ACT_POP;
            gie_set = 1'b1;
         end else if (op_skip && skip_cond) begin
            act = ACT_SKIP;
         end else begin
            act = ACT_STEP;
         end
      end
   end

   // R7
   always_comb begin
      strobe_excl_chk: assert ($onehot0({gie_set, lit_load}));
   end
endmodule

// File: rtl/pc_seq_stack.sv
module pc_seq_stack #(
   parameter int DEPTH = 8,
   parameter int W     = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] rd_data
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if ((1 << PTR_W) != DEPTH || DEPTH < 2) begin : g_depth_bad
      $error("pc_seq_stack: DEPTH must be a power of two of at least 2");
   end

   logic [PTR_W-1:0] sp_q;
   logic [PTR_W-1:0] top_idx;
   logic [W-1:0]     ent [DEPTH];

   assign top_idx = sp_q - 1'b1;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               ent_q <= '0;
         else if (push && sp_q == PTR_W'(g))       ent_q <= wr_data;
      end
      assign ent[g] = ent_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sp_q <= '0;
      else if (push)  sp_q <= sp_q + 1'b1;
      else if (pop)   sp_q <= sp_q - 1'b1;
   end

   assign rd_data = ent[top_idx];

   // R5
   push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> rd_data == $past(wr_data));

   // R6
   push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));
endmodule

// File: rtl/pc_seq.sv
module pc_seq
   import pc_seq_pkg::*;
#(
   parameter int PC_W    = 13,
   parameter int IMM_W   = 11,
   parameter int STACK_D = 8,
   localparam int LATCH_W = PC_W - 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cyc_en,
   input  logic               op_jump,
   input  logic               op_call,
   input  logic               op_ret,
   input  logic               op_retlit,
   input  logic               op_retint,
   input  logic               op_skip,
   input  logic               skip_cond,
   input  logic               pcl_wr,
   input  logic [7:0]         pcl_wdata,
   input  logic [IMM_W-1:0]   jmp_imm,
   input  logic [LATCH_W-1:0] pc_latch,
   output logic [PC_W-1:0]    pc,
   output logic               flush,
   output logic               gie_set,
   output logic               lit_load
);
   if (IMM_W <= 8 || IMM_W >= PC_W) begin : g_width_bad
      $error("pc_seq: IMM_W must lie strictly between 8 and PC_W");
   end

   act_e            act;
   logic [PC_W-1:0] pc_q;
   logic            flush_q;
   logic [PC_W-1:0] far_tgt;
   logic [PC_W-1:0] pcl_tgt;
   logic [PC_W-1:0] ret_addr;

   assign far_tgt = {pc_latch[LATCH_W-1:IMM_W-8], jmp_imm};
   assign pcl_tgt = {pc_latch, pcl_wdata};

   pc_seq_ctrl u_ctrl (
      .cyc_en    (cyc_en),
      .flush     (flush_q),
      .op_jump   (op_jump),
      .op_call   (op_call),
      .op_ret    (op_ret),
      .op_retlit (op_retlit),
      .op_retint (op_retint),
      .op_skip   (op_skip),
      .skip_cond (skip_cond),
      .pcl_wr    (pcl_wr),
      .act       (act),
      .gie_set   (gie_set),
      .lit_load  (lit_load)
   );

   pc_seq_stack #(.DEPTH(STACK_D), .W(PC_W)) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (act == ACT_CALL),
      .pop     (act == ACT_POP),
      .wr_data (pc_q + 1'b1),
      .rd_data (ret_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         flush_q <= 1'b0;
      end else begin
         unique case (act)
            ACT_IDLE: ;
            ACT_DEAD: flush_q <= 1'b0;
            ACT_STEP: begin pc_q <= pc_q + 1'b1;      flush_q <= 1'b0; end
            ACT_SKIP: begin pc_q <= pc_q + PC_W'(2);  flush_q <= 1'b1; end
            ACT_JUMP,
            ACT_CALL: begin pc_q <= far_tgt;          flush_q <= 1'b1; end
            ACT_POP:  begin pc_q <= ret_addr;         flush_q <= 1'b1; end
            ACT_PCL:  begin pc_q <= pcl_tgt;          flush_q <= 1'b1; end
            default:  ;
         endcase
      end
   end

   assign pc    = pc_q;
   assign flush = flush_q;

   // R9
   dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_en && flush) |=> ($stable(pc) && !flush));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_en |=> ($stable(pc) && $stable(flush)));

   // R2
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_en && !flush && !(op_jump || op_call || op_ret || op_retlit ||
       op_retint || pcl_wr || (op_skip && skip_cond)))
      |=> (pc == PC_W'($past(pc) + 1'b1) && !flush));

   // R4
   jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_en && !flush && !pcl_wr && op_jump)
      |=> (pc[IMM_W-1:0] == $past(jmp_imm) && flush));

   // R7
   strobe_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !(gie_set || lit_load));
endmodule

// File: tb/pc_seq_tb.sv
`timescale 1ns/1ps
module pc_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_en = 1'b0;
   logic        op_jump = 1'b0, op_call = 1'b0, op_ret = 1'b0;
   logic        op_retlit = 1'b0, op_retint = 1'b0, op_skip = 1'b0;
   logic        skip_cond = 1'b0, pcl_wr = 1'b0;
   logic [7:0]  pcl_wdata = '0;
   logic [10:0] jmp_imm = '0;
   logic [4:0]  pc_latch = '0;
   logic [12:0] pc;
   logic        flush, gie_set, lit_load;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [12:0] ref_pc = '0;
   logic        ref_flush = 1'b0;
   logic [12:0] ref_stk [8];
   int          ref_sp = 0;

   always #4 clk = ~clk;

   pc_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
      .op_jump(op_jump), .op_call(op_call), .op_ret(op_ret),
      .op_retlit(op_retlit), .op_retint(op_retint), .op_skip(op_skip),
      .skip_cond(skip_cond), .pcl_wr(pcl_wr), .pcl_wdata(pcl_wdata),
      .jmp_imm(jmp_imm), .pc_latch(pc_latch),
      .pc(pc), .flush(flush), .gie_set(gie_set), .lit_load(lit_load)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic ops_clear();
      op_jump = 0; op_call = 0; op_ret = 0; op_retlit = 0;
      op_retint = 0; op_skip = 0; skip_cond = 0; pcl_wr = 0;
   endtask

   // One clock: compute expected next state, check strobes, clock, check state.
   task automatic tick(input string tag_in);
      string       tag;
      logic [12:0] np;
      logic        nf, eg, el;
      eg = 0; el = 0; np = ref_pc; nf = ref_flush; tag = "R2";
      if (!cyc_en) begin
         tag = "R3";
      end else if (ref_flush) begin
         nf = 0; tag = "R9";
      end else begin
         nf = 1;
         if (pcl_wr) begin
            np = {pc_latch, pcl_wdata}; tag = "R10";
         end else if (op_jump) begin
            np = {pc_latch[4:3], jmp_imm}; tag = "R4";
         end else if (op_call) begin
            ref_stk[ref_sp] = ref_pc + 13'd1;
            ref_sp = (ref_sp + 1) % 8;
            np = {pc_latch[4:3], jmp_imm}; tag = "R5";
         end else if (op_ret || op_retlit || op_retint) begin
            ref_sp = (ref_sp + 7) % 8;
            np = ref_stk[ref_sp];
            el = !op_ret && op_retlit;
            eg = !op_ret && !op_retlit;
            tag = "R6";
         end else if (op_skip && skip_cond) begin
            np = ref_pc + 13'd2; tag = "R8";
         end else begin
            np = ref_pc + 13'd1; nf = 0;
            if (op_skip) tag = "R8";
         end
      end
      if (tag_in != "") tag = tag_in;
      #1;
      chk(gie_set == eg, "R7", "gie_set", int'(gie_set), int'(eg));
      chk(lit_load == el, "R7", "lit_load", int'(lit_load), int'(el));
      @(posedge clk);
      ref_pc = np; ref_flush = nf;
      @(negedge clk);
      chk(pc == ref_pc, tag, "pc", int'(pc), int'(ref_pc));
      chk(flush == ref_flush, tag, "flush", int'(flush), int'(ref_flush));
   endtask

   task automatic do_call(input logic [10:0] tgt, input string tag);
      ops_clear(); cyc_en = 1; op_call = 1; jmp_imm = tgt; tick(tag);
      ops_clear(); tick(tag);
   endtask

   task automatic do_ret(input string tag);
      ops_clear(); cyc_en = 1; op_ret = 1; tick(tag);
      ops_clear(); tick(tag);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) ref_stk[i] = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk(pc == 13'd0, "R1", "pc after reset", int'(pc), 0);
      chk(flush == 1'b0, "R1", "flush after reset", int'(flush), 0);
      @(negedge clk);
      // R1: return from an empty, cleared stack lands on 0
      cyc_en = 1; repeat (5) tick("R2");
      do_ret("R1");

      // R3: no cycle strobe, pulses present
      ops_clear(); cyc_en = 0; op_jump = 1; jmp_imm = 11'h123; repeat (3) tick("R3");

      // R4: jump target built from latch[4:3] and immediate, then dead slot
      ops_clear(); cyc_en = 1; pc_latch = 5'b11000; jmp_imm = 11'h5A5; op_jump = 1;
      tick("R4");
      // R9: dead slot ignores a call and a low-byte write
      op_jump = 0; op_call = 1; pcl_wr = 1; tick("R9");
      ops_clear(); tick("R2");

      // R5/R6: nested calls return in reverse order
      pc_latch = 5'b01000;
      do_call(11'h010, "R5"); do_call(11'h200, "R5"); do_call(11'h7FF, "R5");
      do_ret("R6"); do_ret("R6"); do_ret("R6");

      // R7: literal- and interrupt-return strobes
      do_call(11'h044, "R5");
      ops_clear(); op_retlit = 1; tick("R7"); ops_clear(); tick("R9");
      do_call(11'h055, "R5");
      ops_clear(); op_retint = 1; tick("R7"); ops_clear(); tick("R9");

      // R8: taken and untaken skip
      ops_clear(); op_skip = 1; skip_cond = 1; tick("R8");
      ops_clear(); tick("R9");
      op_skip = 1; skip_cond = 0; tick("R8");

      // R10: low-byte write uses all latch bits
      ops_clear(); pcl_wr = 1; pc_latch = 5'b10101; pcl_wdata = 8'hC3; tick("R10");
      ops_clear(); tick("R9");

      // R2: wrap from 0x1FFF
      pc_latch = 5'b11111; pcl_wdata = 8'hFE; pcl_wr = 1; tick("R10");
      ops_clear(); tick("R9"); tick("R2"); tick("R2");

      // R11: nine calls overflow the eight-entry stack
      pc_latch = 5'b00000;
      for (int i = 0; i < 9; i++) do_call(11'(16 * (i + 1)), "R11");
      for (int i = 0; i < 9; i++) do_ret("R11");

      // R12: simultaneous pulses
      ops_clear(); op_jump = 1; op_call = 1; jmp_imm = 11'h333; tick("R12");
      ops_clear(); tick("R9");
      op_call = 1; op_ret = 1; op_skip = 1; skip_cond = 1; jmp_imm = 11'h111; tick("R12");
      ops_clear(); tick("R9");
      op_retlit = 1; op_retint = 1; tick("R12"); ops_clear(); tick("R9");
      pcl_wr = 1; op_jump = 1; pcl_wdata = 8'h5A; tick("R12"); ops_clear(); tick("R9");

      // Constrained random mix
      for (int n = 0; n < 4000; n++) begin
         int r;
         ops_clear();
         cyc_en    = ($urandom % 8) != 0;
         jmp_imm   = 11'($urandom);
         pc_latch  = 5'($urandom);
         pcl_wdata = 8'($urandom);
         skip_cond = 1'($urandom);
         r = $urandom % 16;
         case (r)
            0: op_jump = 1;
            1, 2: op_call = 1;
            3: op_ret = 1;
            4: op_retlit = 1;
            5: op_retint = 1;
            6: pcl_wr = 1;
            7, 8: op_skip = 1;
            default: ;
         endcase
         if ($urandom % 16 == 0) begin
            r = $urandom % 4;
            if (r == 0) op_call = 1;
            if (r == 1) op_ret = 1;
            if (r == 2) op_retint = 1;
            if (r == 3) op_skip = 1;
         end
         tick("");
      end

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      #1600000;
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule